// File: doc/BRIEF.md
# D-PHY Clock Lane High-Speed Sequencer

This block drives a continuous-clock D-PHY clock lane between the low-power stop state and high-speed clocking. A one-cycle request starts the entry sequence. The lane steps from LP-11 through LP-01 and LP-00 into HS-0. The bit clock is then gated on, and after a programmable pre-data hold the block raises a ready flag that lets the data lanes start transmitting. When the data lanes report that they have finished, the clock keeps running for a post-data hold. It then parks at HS-0 for the trail time and returns to LP-11.

Each phase length is a byte-clock count taken from an 8-bit field, where one byte-clock period is eight HS bit periods. Software fills each field with the required time in nanoseconds divided by the byte-clock period, rounded up. The post-data field is expected to hold the clock post time plus the data-lane HS trail time, because both must elapse before the clock may stop. Driving the analog lines and generating the clocks are handled outside this block.

The packed clock timing word sets the bit positions: [31:24] prepare, [23:16] zero, [15:8] post, [7:0] trail. The pre-data count and the LP-01 count are each 8-bit ports of their own. They are the low bytes of their words, and the upper bits of those words are reserved.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: During and after reset, the lane idles at LP-11: lp_p_o=1, lp_n_o=1, hs_en_o=0, hs_clk_gate_o=0, lane_ready_o=0. lp_p_o=1 with lp_n_o=0 never occurs.
- R2: A request seen while idle at LP-11 moves the lane to LP-01 (lp_p_o=0, lp_n_o=1) on the next edge. LP-01 lasts lpx_i cycles. In every phase, a count field of 0 gives a one-cycle phase.
- R3: LP-01 is followed by LP-00 with hs_en_o=0 for clk_timing_i[31:24] cycles.
- R4: LP-00 is followed by HS-0 (hs_en_o=1, hs_clk_gate_o=0, LP lines 00) for clk_timing_i[23:16] cycles. hs_en_o=1 only ever occurs with both LP lines at 0.
- R5: HS-0 is followed by the gated clock with lane_ready_o=0 for pre_timing_i cycles. After that, lane_ready_o=1 together with the clock, and it stays high until data_done_i is seen.
- R6: data_done_i seen while ready drops ready on the next edge. The clock runs for clk_timing_i[15:8] cycles, then HS-0 holds for clk_timing_i[7:0] cycles, and then the lane returns to LP-11.
- R7: A request seen during the post-data hold or the trail is remembered. The lane spends exactly one cycle at LP-11 and then enters LP-01 with no further request.
- R8: A request seen during entry or while ready has no effect. data_done_i has no effect outside the ready state.
- R9: The prepare, zero, post, trail and pre-data counts are captured when a sequence starts. Later changes to clk_timing_i or pre_timing_i do not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Lane byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hs_req_i | input | 1 | Request to start high-speed clocking |
| data_done_i | input | 1 | Data lanes have finished their HS burst |
| clk_timing_i | input | 32 | Packed prepare / zero / post / trail counts |
| pre_timing_i | input | 8 | Pre-data hold count |
| lpx_i | input | 8 | LP-01 step count |
| lp_p_o | output | 1 | LP level for the positive line |
| lp_n_o | output | 1 | LP level for the negative line |
| hs_en_o | output | 1 | HS driver enable |
| hs_clk_gate_o | output | 1 | HS bit-clock gate |
| lane_ready_o | output | 1 | Data lanes may transmit |

## Verification
The bench builds the block with the default 8-bit field width, so every programmable count from 0 to 255 can be reached. Directed sequences use small distinct counts so that an off-by-one in any single phase shows up. An all-zero set exercises the one-cycle minimum. A long randomized stretch draws counts from 0 to 15 and places requests and done pulses inside every phase, which covers the pending-request path and the ignored inputs. A mid-sequence rewrite of the timing word shows that the captured counts are the ones in use.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

   typedef enum logic [2:0] {
      PH_STOP  = 3'd0,
      PH_LPX   = 3'd1,
      PH_PREP  = 3'd2,
      PH_ZERO  = 3'd3,
      PH_PRE   = 3'd4,
      PH_ACT   = 3'd5,
      PH_POST  = 3'd6,
      PH_TRAIL = 3'd7
   } clkseq_phase_e;

   typedef struct packed {
      logic lp_p;
      logic lp_n;
      logic hs_en;
      logic gate;
      logic ready;
   } clkseq_drive_t;

   // slot indices inside the packed clock timing word
   localparam int SLOT_TRAIL = 0;
   localparam int SLOT_POST  = 1;
   localparam int SLOT_ZERO  = 2;
   localparam int SLOT_PREP  = 3;
   localparam int NUM_SLOTS  = 4;

endpackage

// File: rtl/clkseq_cfg_latch.sv
module clkseq_cfg_latch #(
   parameter int FIELD_W = 8,
   localparam int WORD_W = clkseq_pkg::NUM_SLOTS * FIELD_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               capture_i,
   input  logic [WORD_W-1:0]  word_i,
   input  logic [FIELD_W-1:0] pre_i,
   output logic [FIELD_W-1:0] prep_o,
   output logic [FIELD_W-1:0] zero_o,
   output logic [FIELD_W-1:0] post_o,
   output logic [FIELD_W-1:0] trail_o,
   output logic [FIELD_W-1:0] pre_o
);
   import clkseq_pkg::*;

   logic [FIELD_W-1:0] slot_q [NUM_SLOTS];
   logic [FIELD_W-1:0] pre_q;

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)        slot_q[k] <= '0;
         else if (capture_i) slot_q[k] <= word_i[k*FIELD_W +: FIELD_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pre_q <= '0;
      else if (capture_i) pre_q <= pre_i;
   end

   assign prep_o  = slot_q[SLOT_PREP];
   assign zero_o  = slot_q[SLOT_ZERO];
   assign post_o  = slot_q[SLOT_POST];
   assign trail_o = slot_q[SLOT_TRAIL];
   assign pre_o   = pre_q;

endmodule

// File: rtl/clkseq_phase_timer.sv
module clkseq_phase_timer #(
   parameter int FIELD_W = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [FIELD_W-1:0] len_i,
   output logic               expired_o
);
   logic [FIELD_W-1:0] cnt_q;

   // a phase lasts len cycles; a length of zero is stretched to one
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/clkseq_line_drive.sv
module clkseq_line_drive
   import clkseq_pkg::*;
(
   input  clkseq_phase_e phase_i,
   output clkseq_drive_t drive_o
);
   always_comb begin
      drive_o = '{lp_p: 1'b0, lp_n: 1'b0, hs_en: 1'b0, gate: 1'b0, ready: 1'b0};
      unique case (phase_i)
         PH_STOP: begin
            drive_o.lp_p = 1'b1;
            drive_o.lp_n = 1'b1;
         end
         PH_LPX:  drive_o.lp_n = 1'b1;
         PH_PREP: ;
         PH_ZERO, PH_TRAIL: drive_o.hs_en = 1'b1;
         PH_PRE, PH_POST: begin
            drive_o.hs_en = 1'b1;
            drive_o.gate  = 1'b1;
         end
         PH_ACT: begin
            drive_o.hs_en = 1'b1;
            drive_o.gate  = 1'b1;
            drive_o.ready = 1'b1;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
   import clkseq_pkg::*;
#(
   parameter int FIELD_W = 8,
   localparam int WORD_W = NUM_SLOTS * FIELD_W
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               hs_req_i,
   input  logic               data_done_i,
   input  logic [WORD_W-1:0]  clk_timing_i,
   input  logic [FIELD_W-1:0] pre_timing_i,
   input  logic [FIELD_W-1:0] lpx_i,
   output logic               lp_p_o,
   output logic               lp_n_o,
   output logic               hs_en_o,
   output logic               hs_clk_gate_o,
   output logic               lane_ready_o
);

   if (FIELD_W < 2 || FIELD_W > 16) begin : g_bad_width
      $error("dphy_clk_lane_seq: FIELD_W must lie in 2..16");
   end

   clkseq_phase_e      st_q, st_d;
   logic               pend_q;
   logic               start;
   logic               tmr_load;
   logic [FIELD_W-1:0] tmr_len;
   logic               tmr_exp;
   logic [FIELD_W-1:0] f_prep, f_zero, f_post, f_trail, f_pre;
   clkseq_drive_t      drv;

   assign start = (st_q == PH_STOP) && (hs_req_i || pend_q);

   clkseq_cfg_latch #(.FIELD_W(FIELD_W)) cfg_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .capture_i (start),
      .word_i    (clk_timing_i),
      .pre_i     (pre_timing_i),
      .prep_o    (f_prep),
      .zero_o    (f_zero),
      .post_o    (f_post),
      .trail_o   (f_trail),
      .pre_o     (f_pre)
   );

   clkseq_phase_timer #(.FIELD_W(FIELD_W)) tmr_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .len_i     (tmr_len),
      .expired_o (tmr_exp)
   );

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_len  = '0;
      unique case (st_q)
         PH_STOP: if (start) begin
            st_d = PH_LPX;  tmr_load = 1'b1; tmr_len = lpx_i;
         end
         PH_LPX: if (tmr_exp) begin
            st_d = PH_PREP; tmr_load = 1'b1; tmr_len = f_prep;
         end
         PH_PREP: if (tmr_exp) begin
            st_d = PH_ZERO; tmr_load = 1'b1; tmr_len = f_zero;
         end
         PH_ZERO: if (tmr_exp) begin
            st_d = PH_PRE;  tmr_load = 1'b1; tmr_len = f_pre;
         end
         PH_PRE: if (tmr_exp) st_d = PH_ACT;
         PH_ACT: if (data_done_i) begin
            st_d = PH_POST; tmr_load = 1'b1; tmr_len = f_post;
         end
         PH_POST: if (tmr_exp) begin
            st_d = PH_TRAIL; tmr_load = 1'b1; tmr_len = f_trail;
         end
         PH_TRAIL: if (tmr_exp) st_d = PH_STOP;
         default: st_d = PH_STOP;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= PH_STOP;
         pend_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == PH_POST || st_q == PH_TRAIL) pend_q <= pend_q | hs_req_i;
         else if (st_q == PH_STOP)                pend_q <= 1'b0;
      end
   end

   clkseq_line_drive drv_i (
      .phase_i (st_q),
      .drive_o (drv)
   );

   assign lp_p_o        = drv.lp_p;
   assign lp_n_o        = drv.lp_n;
   assign hs_en_o       = drv.hs_en;
   assign hs_clk_gate_o = drv.gate;
   assign lane_ready_o  = drv.ready;

endmodule

// File: rtl/dphy_clk_lane_seq_chk.sv
module dphy_clk_lane_seq_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic hs_req_i,
   input logic data_done_i,
   input logic lp_p_o,
   input logic lp_n_o,
   input logic hs_en_o,
   input logic hs_clk_gate_o,
   input logic lane_ready_o
);

   assert_no_lp10_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(lp_p_o && !lp_n_o));

   assert_stop_exits_to_lp01_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_p_o && lp_n_o) |=> (lp_p_o && lp_n_o) || (!lp_p_o && lp_n_o && !hs_en_o));

   assert_hs_needs_lp00_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_en_o |-> (!lp_p_o && !lp_n_o));

   assert_gate_needs_hs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_clk_gate_o |-> hs_en_o);

   assert_ready_with_clock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_ready_o |-> (hs_clk_gate_o && hs_en_o));

   assert_ready_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_ready_o && !data_done_i) |=> lane_ready_o);

   assert_done_drops_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lane_ready_o && data_done_i) |=> (!lane_ready_o && hs_clk_gate_o));

   assert_hs_off_to_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(hs_en_o) |-> (lp_p_o && lp_n_o));

endmodule

bind dphy_clk_lane_seq dphy_clk_lane_seq_chk chk_i (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .hs_req_i      (hs_req_i),
   .data_done_i   (data_done_i),
   .lp_p_o        (lp_p_o),
   .lp_n_o        (lp_n_o),
   .hs_en_o       (hs_en_o),
   .hs_clk_gate_o (hs_clk_gate_o),
   .lane_ready_o  (lane_ready_o)
);

// File: tb/dphy_clk_lane_seq_tb_top.sv
module dphy_clk_lane_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        done = 1'b0;
   logic [31:0] clk_w = '0;
   logic [7:0]  pre_w = '0;
   logic [7:0]  lpx_w = '0;
   logic        lp_p, lp_n, hs_en, gate, ready;

   int vectors = 0;
   int miscompares = 0;

   // behavioural reference: phase 0 idle,1 lp01,2 lp00,3 hs0,4 pre,5 ready,6 post,7 trail
   int mph = 0;
   int mleft = 0;
   bit mpend = 1'b0;
   int s_prep, s_zero, s_post, s_trail, s_pre;

   always #(CLK_PERIOD/2) clk = ~clk;

   dphy_clk_lane_seq #(.FIELD_W(FW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .hs_req_i(req), .data_done_i(done),
      .clk_timing_i(clk_w), .pre_timing_i(pre_w), .lpx_i(lpx_w),
      .lp_p_o(lp_p), .lp_n_o(lp_n), .hs_en_o(hs_en),
      .hs_clk_gate_o(gate), .lane_ready_o(ready)
   );

   function automatic int plen(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic logic [4:0] expect_bits(input int ph);
      case (ph)
         0: return 5'b11000;
         1: return 5'b01000;
         2: return 5'b00000;
         3: return 5'b00100;
         4: return 5'b00110;
         5: return 5'b00111;
         6: return 5'b00110;
         default: return 5'b00100;
      endcase
   endfunction

   function automatic string tag_of(input int ph);
      case (ph)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4, 5: return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic model_step();
      bit newp;
      newp = (mph == 6 || mph == 7) ? (mpend | req) : 1'b0;
      if (mph == 0) begin
         if (req || mpend) begin
            s_prep = clk_w[31:24]; s_zero = clk_w[23:16];
            s_post = clk_w[15:8];  s_trail = clk_w[7:0]; s_pre = pre_w;
            mph = 1; mleft = plen(lpx_w);
         end
      end else if (mph == 5) begin
         if (done) begin mph = 6; mleft = plen(s_post); end
      end else begin
         mleft--;
         if (mleft == 0) begin
            case (mph)
               1: begin mph = 2; mleft = plen(s_prep); end
               2: begin mph = 3; mleft = plen(s_zero); end
               3: begin mph = 4; mleft = plen(s_pre); end
               4: mph = 5;
               6: begin mph = 7; mleft = plen(s_trail); end
               default: mph = 0;
            endcase
         end
      end
      mpend = newp;
   endtask

   task automatic compare();
      logic [4:0] got, exp;
      got = {lp_p, lp_n, hs_en, gate, ready};
      exp = expect_bits(mph);
      vectors++;
      if (got !== exp) begin
         miscompares++;
         $display("FAIL %s phase %0d lines got %b expected %b at %0t",
                  tag_of(mph), mph, got, exp, $time);
      end
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      vectors++;
      if (got != exp) begin
         miscompares++;
         $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // one clock: model consumes the inputs the DUT sees at this edge
   task automatic tick();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic run_until(input int ph);
      for (int i = 0; i < 1000 && mph != ph; i++) tick();
      chk("R6 reach phase", mph, ph);
   endtask

   task automatic pulse_req();
      req = 1'b1; tick(); req = 1'b0;
   endtask

   task automatic finish_burst();
      run_until(5);
      tick(); tick();
      done = 1'b1; tick(); done = 1'b0;
      run_until(0);
      tick();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) begin @(negedge clk); compare(); end
      rst_n = 1'b1;
      tick(); tick();

      // basic sequence with distinct counts
      clk_w = 32'h02050302; pre_w = 8'd4; lpx_w = 8'd3;
      pulse_req();
      run_until(5);
      chk("R5 ready while active", ready, 1);
      repeat (5) tick();
      done = 1'b1; tick(); done = 1'b0;
      chk("R6 ready dropped", ready, 0);
      run_until(0);
      tick();

      // R9: rewrite timing after start, measure HS-0 before clock
      begin
         int hs0 = 0;
         pulse_req();
         clk_w = 32'h09090909; pre_w = 8'd9;
         for (int i = 0; i < 200 && !gate; i++) begin
            if (hs_en && !gate) hs0++;
            tick();
         end
         chk("R9 captured zero count", hs0, 5);
         finish_burst();
      end

      // R2: all counts zero give one-cycle phases
      begin
         int n01 = 0;
         clk_w = '0; pre_w = '0; lpx_w = '0;
         pulse_req();
         for (int i = 0; i < 10; i++) begin
            if (!lp_p && lp_n) n01++;
            tick();
         end
         chk("R2 zero count one cycle", n01, 1);
         finish_burst();
      end

      // R7: request during post is held until LP-11
      clk_w = 32'h01020403; pre_w = 8'd2; lpx_w = 8'd2;
      pulse_req();
      run_until(5);
      done = 1'b1; tick(); done = 1'b0;
      tick();
      pulse_req();
      for (int i = 0; i < 100 && !(lp_p && lp_n); i++) tick();
      chk("R7 idle one cycle", {30'd0, lp_p, lp_n}, 3);
      tick();
      chk("R7 pending entry to LP-01", {30'd0, lp_p, lp_n}, 1);
      finish_burst();

      // R8: request during entry and done before ready are ignored
      pulse_req();
      run_until(3);
      pulse_req();
      run_until(4);
      done = 1'b1; tick(); done = 1'b0;
      chk("R8 done ignored before ready", hs_en, 1);
      finish_burst();
      repeat (10) tick();
      chk("R8 no re-entry after ignored request", {29'd0, lp_p, lp_n, hs_en}, 6);

      // randomized stretch
      for (int i = 0; i < 4000; i++) begin
         if (mph == 0) begin
            clk_w = {4'd0, 4'($urandom_range(0, 15)), 4'd0, 4'($urandom_range(0, 15)),
                     4'd0, 4'($urandom_range(0, 15)), 4'd0, 4'($urandom_range(0, 15))};
            pre_w = 8'($urandom_range(0, 15));
            lpx_w = 8'($urandom_range(0, 15));
         end
         req  = ($urandom_range(0, 9) == 0);
         done = ($urandom_range(0, 7) == 0);
         tick();
      end
      req = 1'b0; done = 1'b0;
      repeat (5) tick();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule